// File: doc/BRIEF.md
# Coherence Directory Entry Controller

This block is the home-node bookkeeping for a single memory block in a directory-based coherence scheme. It records whether the block is uncached, shared or exclusive. It also keeps a dirty flag and one presence bit per processor. Requests arrive one at a time from a known processor: a read miss, a write miss or a writeback. The block answers each one with point-to-point messages addressed to the processors involved, so nothing is ever broadcast.

When other caches must give up or hand back their copy, the controller sends the messages and then drops its ready output. It waits for an explicit response from every targeted processor. Once the last response arrives, it updates the directory and sends the data reply to the requester. Every accepted request ends in exactly one reply to its requester: a data reply for a miss, an acknowledgement for a writeback.

Top module: `coh_dir_entry`

## Requirements
- R1: After reset the directory is uncached (state code 0) with all presence bits and the dirty bit clear, `req_ready_o` is 1 and no message is valid.
- R2: A read miss (request code 0) to an uncached or shared block sets the requester's presence bit, clears dirty and leaves the block shared (state code 1). A data reply (message code 3) addressed one-hot to the requester appears in the cycle after acceptance.
- R3: A write miss (request code 1) when no processor other than the requester holds the block makes the requester the sole holder, sets dirty and moves the block to exclusive (state code 2). A data reply goes to the requester in the cycle after acceptance.
- R4: A write miss to a shared block that other processors hold sends one invalidate (message code 0) in the cycle after acceptance. Its destination bitmask is every holder except the requester. After the last of those processors responds, the requester becomes the sole owner with dirty set, and the data reply follows in the next cycle.
- R5: A write miss to a block owned exclusively by another processor sends a fetch-and-invalidate (message code 2) to the owner. After the owner responds, the requester is the sole owner, dirty stays set, and the data reply follows.
- R6: A read miss to a block owned exclusively by another processor sends a fetch (message code 1) to the owner. After the owner responds, the block is shared by the owner and the requester with dirty clear, and the data reply follows.
- R7: A writeback (request code 2) from the exclusive owner returns the block to uncached with no presence bits and dirty clear. A writeback from any other processor changes nothing. Both receive an acknowledgement (message code 4) in the cycle after acceptance.
- R8: While responses are outstanding, `req_ready_o` is 0 and requests are not accepted. A response from a processor that is not awaited changes nothing and produces no message.
- R9: A request with code 3 is accepted but ignored: no message and no change to the directory.
- R10: The directory stays consistent at all times. Uncached has no presence bits and dirty clear. Shared has at least one presence bit and dirty clear. Exclusive has dirty set and exactly one presence bit. Every message except an invalidate names exactly one destination.
- R11: A read or write miss from the processor that already owns the block exclusively receives an immediate data reply, and the directory is left exclusive with that owner and dirty set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_kind_i | input | 2 | 0 read miss, 1 write miss, 2 writeback, 3 ignored |
| req_src_i | input | 2 | Requesting processor ID |
| rsp_valid_i | input | 1 | Response (invalidate ack or fetched data) present |
| rsp_src_i | input | 2 | Responding processor ID |
| msg_valid_o | output | 1 | Outgoing message valid for one cycle |
| msg_kind_o | output | 3 | 0 invalidate, 1 fetch, 2 fetch-invalidate, 3 data reply, 4 writeback ack |
| msg_dest_o | output | 4 | Destination bitmask |
| dir_state_o | output | 2 | 0 uncached, 1 shared, 2 exclusive |
| dir_dirty_o | output | 1 | Dirty flag |
| dir_presence_o | output | 4 | Presence bit per processor |

## Verification
Every message is registered. It appears in the cycle after the edge that accepts its request or takes in the final awaited response. The directory outputs change at that same edge. The bench drives inputs on the falling edge and samples one falling edge later, so each result is read exactly one clock after its cause. In waits, it checks that ready stays low and nothing is sent after a stray response or after each non-final awaited response, and that the data reply comes exactly one cycle after the final one.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    DIR_UNCACHED = 2'd0,
    DIR_SHARED   = 2'd1,
    DIR_EXCL     = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WB    = 2'd2,
    REQ_NOP   = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    MSG_INVAL     = 3'd0,
    MSG_FETCH     = 3'd1,
    MSG_FETCH_INV = 3'd2,
    MSG_DATA      = 3'd3,
    MSG_WB_ACK    = 3'd4
  } msg_kind_e;
endpackage

// File: rtl/coh_dir_decide.sv
module coh_dir_decide
  import coh_dir_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input  dir_state_e        st_i,
  input  logic              dirty_i,
  input  logic [N_PROC-1:0] pres_i,
  input  req_kind_e         kind_i,
  input  logic [N_PROC-1:0] src_oh_i,
  output logic              wait_o,
  output logic [N_PROC-1:0] wait_mask_o,
  output logic              msg_en_o,
  output msg_kind_e         msg_kind_o,
  output logic [N_PROC-1:0] msg_dest_o,
  output dir_state_e        nxt_st_o,
  output logic              nxt_dirty_o,
  output logic [N_PROC-1:0] nxt_pres_o
);
  logic [N_PROC-1:0] others;
  assign others = pres_i & ~src_oh_i;

  always_comb begin
    wait_o      = 1'b0;
    wait_mask_o = '0;
    msg_en_o    = 1'b0;
    msg_kind_o  = MSG_DATA;
    msg_dest_o  = src_oh_i;
    nxt_st_o    = st_i;
    nxt_dirty_o = dirty_i;
    nxt_pres_o  = pres_i;
    unique case (kind_i)
      REQ_READ: begin
        msg_en_o = 1'b1;
        if (st_i == DIR_EXCL && others != '0) begin
          wait_o      = 1'b1;
          wait_mask_o = others;
          msg_kind_o  = MSG_FETCH;
          msg_dest_o  = others;
        end else if (st_i != DIR_EXCL) begin
          nxt_st_o    = DIR_SHARED;
          nxt_dirty_o = 1'b0;
          nxt_pres_o  = pres_i | src_oh_i;
        end
      end
      REQ_WRITE: begin
        msg_en_o = 1'b1;
        if (others != '0) begin
          wait_o      = 1'b1;
          wait_mask_o = others;
          msg_kind_o  = (st_i == DIR_EXCL) ? MSG_FETCH_INV : MSG_INVAL;
          msg_dest_o  = others;
        end else begin
          nxt_st_o    = DIR_EXCL;
          nxt_dirty_o = 1'b1;
          nxt_pres_o  = src_oh_i;
        end
      end
      REQ_WB: begin
        msg_en_o   = 1'b1;
        msg_kind_o = MSG_WB_ACK;
        if (st_i == DIR_EXCL && pres_i == src_oh_i) begin
          nxt_st_o    = DIR_UNCACHED;
          nxt_dirty_o = 1'b0;
          nxt_pres_o  = '0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_dir_ack_track.sv
module coh_dir_ack_track #(
  parameter int N_PROC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_PROC-1:0] mask_i,
  input  logic              is_write_i,
  input  logic [N_PROC-1:0] src_oh_i,
  input  logic              rsp_valid_i,
  input  logic [N_PROC-1:0] rsp_oh_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              is_write_o,
  output logic [N_PROC-1:0] src_oh_o
);
  logic [N_PROC-1:0] pend_q, clr, left;

  assign clr    = rsp_valid_i ? (rsp_oh_i & pend_q) : '0;
  assign left   = pend_q & ~clr;
  assign busy_o = |pend_q;
  assign done_o = busy_o && (left == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      is_write_o <= 1'b0;
      src_oh_o   <= '0;
    end else if (start_i) begin
      pend_q     <= mask_i;
      is_write_o <= is_write_i;
      src_oh_o   <= src_oh_i;
    end else begin
      pend_q <= left;
    end
  end

  assert_no_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_done_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_stray_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && (clr == '0)) |=> $stable(pend_q));
endmodule

// File: rtl/coh_dir_msg_reg.sv
module coh_dir_msg_reg
  import coh_dir_pkg::*;
#(
  parameter int N_PROC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  msg_kind_e         kind_i,
  input  logic [N_PROC-1:0] dest_i,
  output logic              valid_o,
  output msg_kind_e         kind_o,
  output logic [N_PROC-1:0] dest_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= MSG_DATA;
      dest_o  <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        kind_o <= kind_i;
        dest_o <= dest_i;
      end
    end
  end

  assert_single_dest_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o != MSG_INVAL) |-> ($countones(dest_o) == 1));
  assert_inval_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && kind_o == MSG_INVAL) |-> (dest_o != '0));
endmodule

// File: rtl/coh_dir_entry.sv
module coh_dir_entry
  import coh_dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int ID_W   = $clog2(N_PROC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ID_W-1:0]   req_src_i,
  input  logic              rsp_valid_i,
  input  logic [ID_W-1:0]   rsp_src_i,
  output logic              msg_valid_o,
  output logic [2:0]        msg_kind_o,
  output logic [N_PROC-1:0] msg_dest_o,
  output logic [1:0]        dir_state_o,
  output logic              dir_dirty_o,
  output logic [N_PROC-1:0] dir_presence_o
);
  localparam logic [N_PROC-1:0] ONE = {{(N_PROC-1){1'b0}}, 1'b1};

  dir_state_e        st_q, st_d, dc_st;
  logic              dirty_q, dirty_d, dc_dirty;
  logic [N_PROC-1:0] pres_q, pres_d, dc_pres;
  logic [N_PROC-1:0] src_oh, rsp_oh, dc_mask, dc_dest, trk_src, out_dest, mo_dest;
  logic              accept, dc_wait, dc_msg_en, busy, done, trk_write, out_en;
  msg_kind_e         dc_kind, out_kind, mo_kind;
  req_kind_e         kind;

  assign kind        = req_kind_e'(req_kind_i);
  assign src_oh      = ONE << req_src_i;
  assign rsp_oh      = ONE << rsp_src_i;
  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  coh_dir_decide #(.N_PROC(N_PROC)) u_decide (
    .st_i(st_q), .dirty_i(dirty_q), .pres_i(pres_q), .kind_i(kind), .src_oh_i(src_oh),
    .wait_o(dc_wait), .wait_mask_o(dc_mask), .msg_en_o(dc_msg_en), .msg_kind_o(dc_kind),
    .msg_dest_o(dc_dest), .nxt_st_o(dc_st), .nxt_dirty_o(dc_dirty), .nxt_pres_o(dc_pres)
  );

  coh_dir_ack_track #(.N_PROC(N_PROC)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept && dc_wait), .mask_i(dc_mask),
    .is_write_i(kind == REQ_WRITE), .src_oh_i(src_oh), .rsp_valid_i(rsp_valid_i),
    .rsp_oh_i(rsp_oh), .busy_o(busy), .done_o(done), .is_write_o(trk_write),
    .src_oh_o(trk_src)
  );

  always_comb begin
    st_d     = st_q;
    dirty_d  = dirty_q;
    pres_d   = pres_q;
    out_en   = 1'b0;
    out_kind = MSG_DATA;
    out_dest = trk_src;
    if (done) begin
      out_en = 1'b1;
      if (trk_write) begin
        st_d    = DIR_EXCL;
        dirty_d = 1'b1;
        pres_d  = trk_src;
      end else begin
        st_d    = DIR_SHARED;
        dirty_d = 1'b0;
        pres_d  = pres_q | trk_src;
      end
    end else if (accept) begin
      out_en   = dc_msg_en;
      out_kind = dc_kind;
      out_dest = dc_dest;
      if (!dc_wait) begin
        st_d    = dc_st;
        dirty_d = dc_dirty;
        pres_d  = dc_pres;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= DIR_UNCACHED;
      dirty_q <= 1'b0;
      pres_q  <= '0;
    end else begin
      st_q    <= st_d;
      dirty_q <= dirty_d;
      pres_q  <= pres_d;
    end
  end

  coh_dir_msg_reg #(.N_PROC(N_PROC)) u_msg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(out_en), .kind_i(out_kind), .dest_i(out_dest),
    .valid_o(msg_valid_o), .kind_o(mo_kind), .dest_o(mo_dest)
  );

  assign msg_kind_o     = mo_kind;
  assign msg_dest_o     = mo_dest;
  assign dir_state_o    = st_q;
  assign dir_dirty_o    = dirty_q;
  assign dir_presence_o = pres_q;

  assert_uncached_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == DIR_UNCACHED) |-> (pres_q == '0 && !dirty_q));
  assert_shared_clean_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == DIR_SHARED) |-> (pres_q != '0 && !dirty_q));
  assert_excl_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == DIR_EXCL) |-> (dirty_q && $countones(pres_q) == 1));
  assert_wait_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> ($stable(st_q) && $stable(pres_q) && $stable(dirty_q)));
  assert_inv_skips_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && msg_valid_o && mo_kind == MSG_INVAL) |-> ((mo_dest & trk_src) == '0));
  assert_reply_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (msg_valid_o && mo_kind == MSG_DATA && mo_dest == $past(trk_src)));
  assert_nop_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == REQ_NOP) |=> (!msg_valid_o && $stable(st_q) && $stable(pres_q)));
endmodule

// File: tb/coh_dir_entry_tb.sv
`timescale 1ns/1ps
module coh_dir_entry_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_src = 2'd0;
  logic       rsp_valid = 1'b0;
  logic [1:0] rsp_src = 2'd0;
  logic       msg_valid;
  logic [2:0] msg_kind;
  logic [3:0] msg_dest;
  logic [1:0] dir_state;
  logic       dir_dirty;
  logic [3:0] dir_pres;

  int n_chk = 0;
  int n_fail = 0;
  int es = 0;
  logic [3:0] ep = 4'd0;
  logic ed = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;

  always #2.5 clk = ~clk;

  coh_dir_entry u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_src_i(req_src), .rsp_valid_i(rsp_valid), .rsp_src_i(rsp_src),
    .msg_valid_o(msg_valid), .msg_kind_o(msg_kind), .msg_dest_o(msg_dest),
    .dir_state_o(dir_state), .dir_dirty_o(dir_dirty), .dir_presence_o(dir_pres)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_dir(input string tag);
    chk(dir_state == 2'(es), tag, "state", dir_state, es);
    chk(dir_pres == ep, tag, "presence", dir_pres, ep);
    chk(dir_dirty == ed, tag, "dirty", dir_dirty, ed);
  endtask

  task automatic chk_msg(input string tag, input bit v, input int k, input logic [3:0] d);
    chk(msg_valid == v, tag, "msg_valid", msg_valid, v);
    if (v) begin
      chk(msg_kind == 3'(k), tag, "msg_kind", msg_kind, k);
      chk(msg_dest == d, tag, "msg_dest", msg_dest, d);
    end
  endtask

  // k: 0 read, 1 write, 2 writeback, 3 ignored
  task automatic do_req(input int k, input int s);
    logic [3:0] soh = 4'b0001 << s;
    logic [3:0] oth = ep & ~soh;
    logic [3:0] mask = 4'd0;
    int mk = 3;
    bit wt = 1'b0;
    bit vout = 1'b1;
    string tag = "R2";
    int fs = es;
    logic [3:0] fp = ep;
    logic fd = ed;
    case (k)
      0: if (es == 2 && oth != 0) begin
           wt = 1; mask = oth; mk = 1; tag = "R6";
           fs = 1; fp = ep | soh; fd = 0;
         end else if (es == 2) tag = "R11";
         else begin fs = 1; fp = ep | soh; fd = 0; end
      1: if (oth != 0) begin
           wt = 1; mask = oth; mk = (es == 2) ? 2 : 0; tag = (es == 2) ? "R5" : "R4";
           fs = 2; fp = soh; fd = 1;
         end else begin
           tag = (es == 2) ? "R11" : "R3"; fs = 2; fp = soh; fd = 1;
         end
      2: begin
           mk = 4; tag = "R7";
           if (es == 2 && ep == soh) begin fs = 0; fp = 0; fd = 0; end
         end
      default: begin vout = 0; tag = "R9"; end
    endcase
    chk(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
    req_valid = 1; req_kind = 2'(k); req_src = 2'(s);
    @(negedge clk);
    if (!wt) begin
      req_valid = 0;
      chk_msg(tag, vout, mk, soh);
      es = fs; ep = fp; ed = fd;
      chk_dir(tag);
      return;
    end
    chk_msg(tag, 1, mk, mask);
    chk(req_ready == 1'b0, "R8", "ready while waiting", req_ready, 0);
    // keep a competing request up during the wait; it must not be taken
    req_kind = 2'd1; req_src = 2'(s ^ 1);
    rsp_valid = 1; rsp_src = 2'(s);
    @(negedge clk);
    rsp_valid = 0;
    chk_msg("R8", 0, 0, 0);
    chk_dir("R8");
    chk(req_ready == 1'b0, "R8", "ready after stray response", req_ready, 0);
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) begin
        mask[i] = 1'b0;
        rsp_valid = 1; rsp_src = 2'(i);
        if (mask == 0) req_valid = 0;
        @(negedge clk);
        rsp_valid = 0;
        if (mask == 0) begin
          chk_msg(tag, 1, 3, soh);
          es = fs; ep = fp; ed = fd;
          chk_dir(tag);
          chk(req_ready == 1'b1, "R8", "ready after last response", req_ready, 1);
        end else begin
          chk_msg("R8", 0, 0, 0);
          chk_dir("R8");
          chk(req_ready == 1'b0, "R8", "ready mid wait", req_ready, 0);
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
    chk_msg("R1", 0, 0, 0);
    chk_dir("R1");
    // directed walk through every transition
    do_req(3, 0);          // R9 on uncached
    do_req(0, 0);          // R2 uncached -> shared
    do_req(0, 2);          // R2 add sharer
    do_req(0, 3);          // R2 third sharer
    do_req(1, 2);          // R4 invalidate 0 and 3
    do_req(0, 2);          // R11 owner read
    do_req(1, 2);          // R11 owner write
    do_req(2, 1);          // R7 non-owner writeback
    do_req(1, 1);          // R5 ownership move
    do_req(0, 3);          // R6 fetch from owner
    do_req(2, 3);          // R7 writeback while shared: ignored
    do_req(1, 3);          // R4 single other sharer
    do_req(2, 3);          // R7 owner writeback -> uncached
    do_req(1, 0);          // R3 write to uncached
    do_req(3, 2);          // R9 on exclusive
    do_req(2, 0);          // R7
    do_req(0, 1);          // R2
    do_req(1, 1);          // R3 sole sharer upgrades
    // pseudo-random sweep over all kinds and sources
    for (int n = 0; n < 600; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_req(int'(lcg[29:28]), int'(lcg[25:24]));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule